// File: doc/BRIEF.md
# Device Reset Sequencer with Retry

This block brings an attached device out of reset in a controlled way. A start pulse makes it drive the device's active-low reset pin low for three back-to-back timed intervals (1 ms, 1 ms and 2 ms, so 4 ms in all). It then releases the pin and waits 15 ms while the device's internal timers and clock synthesiser settle. A further 1 ms wait lets the device's serial link stabilise. All time is derived from one free-running clock through a parameter that gives the number of clock cycles in a millisecond.

In the single cycle after the last wait, the sequencer samples the device's status. The start is clean only when the reset-timer-expired flag is set, the serial-PLL-expired flag is set, and every monitored clock-loss flag is clear. A parameter mask selects which clock-loss flags are monitored. On a clean start the sequencer raises done. Otherwise it runs the whole sequence again, reset pulse included. If the last permitted attempt (three by default) also fails, it raises fail. Either result stays up until the next start pulse. A start pulse that arrives while a sequence is running has no effect.

Top module: `dev_reset_seq`

## Requirements
- R1: After reset the sequencer is idle: dev_rst_n_o is 1, and busy_o, done_o and fail_o are 0. Whenever busy_o is 0, dev_rst_n_o is 1.
- R2: A start pulse seen at a clock edge while idle, done or failed pulls dev_rst_n_o low and raises busy_o from the next cycle. The pin stays low for exactly (HOLD_A_MS+HOLD_B_MS+HOLD_C_MS)*CYC_PER_MS cycles, which is 4 ms by default.
- R3: After the pin is released, busy_o stays 1 and no result is given for a further (SETTLE_MS+SERIAL_MS)*CYC_PER_MS cycles, which is 16 ms by default.
- R4: Status is sampled in exactly one cycle: the cycle that starts 20 ms after the attempt began. A pass (tmr_expired_i=1, spll_expired_i=1, all monitored loss_i bits 0) raises done_o one cycle later. With a single attempt, done_o is therefore seen 20*CYC_PER_MS+1 cycles after the start edge.
- R5: A loss_i bit whose MONITOR_MASK bit is 0 has no effect on the check.
- R6: A failed check with attempts left drives dev_rst_n_o low again in the next cycle and restarts the full sequence. Each attempt takes 20*CYC_PER_MS+1 cycles.
- R7: When the check fails on attempt MAX_TRIES (3), fail_o rises, busy_o falls and dev_rst_n_o is 1. At most one of busy_o, done_o and fail_o is 1 at any time.
- R8: A start pulse while busy_o is 1 does not change the pin, the timing or the result.
- R9: done_o and fail_o hold until the next start pulse. That pulse clears them when it launches a new sequence.
- R10: Status input values in any cycle other than the sampling cycle do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| tmr_expired_i | input | 1 | Device reset timer has expired |
| loss_i | input | N_LOSS | Device clock-loss (out-of-lock) flags |
| spll_expired_i | input | 1 | Device serial PLL timer has expired |
| dev_rst_n_o | output | 1 | Active-low reset pin to the device |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Device started cleanly |
| fail_o | output | 1 | All attempts failed |

## Verification
The assertions assume that the status inputs and start_i are synchronous to clk and settle before each edge. They also assume that the status seen in the sampling cycle is the only status that matters, so no property relates status values in other cycles to the outcome. The stimulus changes all inputs only on the falling edge. Outside each sampling cycle it holds the status at the worst-case failing pattern, and in the sampling cycle it applies a planned value for each attempt. This also exercises R10. Start pulses are single-cycle, and some of them are sent deliberately while a sequence is running.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_HOLD_A = 4'd1,
    ST_HOLD_B = 4'd2,
    ST_HOLD_C = 4'd3,
    ST_SETTLE = 4'd4,
    ST_SERIAL = 4'd5,
    ST_CHECK  = 4'd6,
    ST_DONE   = 4'd7,
    ST_FAIL   = 4'd8
  } seq_state_e;

  function automatic logic st_pin_low(input seq_state_e s);
    return (s == ST_HOLD_A) || (s == ST_HOLD_B) || (s == ST_HOLD_C);
  endfunction

  function automatic logic st_busy(input seq_state_e s);
    return !((s == ST_IDLE) || (s == ST_DONE) || (s == ST_FAIL));
  endfunction

  function automatic logic st_timed(input seq_state_e s);
    return st_pin_low(s) || (s == ST_SETTLE) || (s == ST_SERIAL);
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rstseq_ms_timer.sv
module rstseq_ms_timer #(
  parameter int unsigned CYC_PER_MS = 50000,
  parameter int unsigned MS_W       = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic            restart_i,
  input  logic [MS_W-1:0] dur_ms_i,
  output logic            expire_o
);

  localparam int unsigned PRE_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_MS - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [MS_W-1:0]  ms_q, ms_d;
  logic             pre_wrap;
  logic             cnt_en;

  assign pre_wrap = (pre_q == PRE_LAST);
  assign cnt_en   = run_i | restart_i;

  // next-state: restart clears, otherwise prescaler wraps into ms counter
  always_comb begin
    pre_d = pre_q;
    ms_d  = ms_q;
    if (restart_i) begin
      pre_d = '0;
      ms_d  = '0;
    end else if (pre_wrap) begin
      pre_d = '0;
      ms_d  = ms_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (cnt_en) begin
      pre_q <= pre_d;
      ms_q  <= ms_d;
    end
  end

  assign expire_o = run_i & pre_wrap & (ms_q == (dur_ms_i - 1'b1));

endmodule

// File: rtl/rstseq_status_eval.sv
module rstseq_status_eval #(
  parameter int unsigned           N_LOSS       = 4,
  parameter logic [N_LOSS-1:0]     MONITOR_MASK = '1
) (
  input  logic              tmr_expired_i,
  input  logic [N_LOSS-1:0] loss_i,
  input  logic              spll_expired_i,
  output logic              pass_o
);

  logic [N_LOSS-1:0] watched;

  // only flags selected by the mask can veto a pass
  for (genvar gi = 0; gi < N_LOSS; gi++) begin : g_watch
    if (MONITOR_MASK[gi]) begin : g_on
      assign watched[gi] = loss_i[gi];
    end else begin : g_off
      assign watched[gi] = 1'b0 & loss_i[gi];
    end
  end

  assign pass_o = tmr_expired_i & spll_expired_i & ~(|watched);

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int unsigned MAX_TRIES = 3,
  parameter int unsigned MS_W      = 5,
  parameter int unsigned HOLD_A_MS = 1,
  parameter int unsigned HOLD_B_MS = 1,
  parameter int unsigned HOLD_C_MS = 2,
  parameter int unsigned SETTLE_MS = 15,
  parameter int unsigned SERIAL_MS = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            expire_i,
  input  logic            pass_i,
  output seq_state_e      state_d,
  output logic            run_o,
  output logic            restart_o,
  output logic [MS_W-1:0] dur_ms_o
);

  localparam int unsigned TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(MAX_TRIES);

  seq_state_e       state_q;
  logic [TRY_W-1:0] tries_q, tries_d;
  logic             try_en;
  logic             launch;
  logic             retry;

  assign launch = start_i & ~st_busy(state_q);
  assign retry  = (state_q == ST_CHECK) & ~pass_i & (tries_q < TRY_LAST);

  // next-state process
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE, ST_FAIL: if (start_i)  state_d = ST_HOLD_A;
      ST_HOLD_A:                 if (expire_i) state_d = ST_HOLD_B;
      ST_HOLD_B:                 if (expire_i) state_d = ST_HOLD_C;
      ST_HOLD_C:                 if (expire_i) state_d = ST_SETTLE;
      ST_SETTLE:                 if (expire_i) state_d = ST_SERIAL;
      ST_SERIAL:                 if (expire_i) state_d = ST_CHECK;
      ST_CHECK: begin
        if (pass_i)     state_d = ST_DONE;
        else if (retry) state_d = ST_HOLD_A;
        else            state_d = ST_FAIL;
      end
      default:                   state_d = ST_IDLE;
    endcase
  end

  // attempt counter next-state
  always_comb begin
    try_en  = 1'b0;
    tries_d = tries_q;
    if (launch) begin
      try_en  = 1'b1;
      tries_d = TRY_W'(1);
    end else if (retry) begin
      try_en  = 1'b1;
      tries_d = tries_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tries_q <= '0;
    end else if (try_en) begin
      tries_q <= tries_d;
    end
  end

  // phase duration select
  always_comb begin
    dur_ms_o = MS_W'(1);
    unique case (state_q)
      ST_HOLD_A: dur_ms_o = MS_W'(HOLD_A_MS);
      ST_HOLD_B: dur_ms_o = MS_W'(HOLD_B_MS);
      ST_HOLD_C: dur_ms_o = MS_W'(HOLD_C_MS);
      ST_SETTLE: dur_ms_o = MS_W'(SETTLE_MS);
      ST_SERIAL: dur_ms_o = MS_W'(SERIAL_MS);
      default:   dur_ms_o = MS_W'(1);
    endcase
  end

  assign run_o     = st_timed(state_q);
  assign restart_o = (state_d != state_q);

endmodule

// File: rtl/dev_reset_seq.sv
module dev_reset_seq
  import rstseq_pkg::*;
#(
  parameter int unsigned       CYC_PER_MS   = 50000,
  parameter int unsigned       N_LOSS       = 4,
  parameter logic [N_LOSS-1:0] MONITOR_MASK = '1,
  parameter int unsigned       MAX_TRIES    = 3,
  parameter int unsigned       HOLD_A_MS    = 1,
  parameter int unsigned       HOLD_B_MS    = 1,
  parameter int unsigned       HOLD_C_MS    = 2,
  parameter int unsigned       SETTLE_MS    = 15,
  parameter int unsigned       SERIAL_MS    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              tmr_expired_i,
  input  logic [N_LOSS-1:0] loss_i,
  input  logic              spll_expired_i,
  output logic              dev_rst_n_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o
);

  localparam int unsigned MAX_MS = umax(umax(umax(HOLD_A_MS, HOLD_B_MS), umax(HOLD_C_MS, SETTLE_MS)), SERIAL_MS);
  localparam int unsigned MS_W   = $clog2(MAX_MS + 1);

  seq_state_e      state_d;
  logic            run;
  logic            restart;
  logic            expire;
  logic            pass;
  logic [MS_W-1:0] dur_ms;

  rstseq_ctrl #(
    .MAX_TRIES (MAX_TRIES),
    .MS_W      (MS_W),
    .HOLD_A_MS (HOLD_A_MS),
    .HOLD_B_MS (HOLD_B_MS),
    .HOLD_C_MS (HOLD_C_MS),
    .SETTLE_MS (SETTLE_MS),
    .SERIAL_MS (SERIAL_MS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .expire_i  (expire),
    .pass_i    (pass),
    .state_d   (state_d),
    .run_o     (run),
    .restart_o (restart),
    .dur_ms_o  (dur_ms)
  );

  rstseq_ms_timer #(
    .CYC_PER_MS (CYC_PER_MS),
    .MS_W       (MS_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .restart_i (restart),
    .dur_ms_i  (dur_ms),
    .expire_o  (expire)
  );

  rstseq_status_eval #(
    .N_LOSS       (N_LOSS),
    .MONITOR_MASK (MONITOR_MASK)
  ) u_eval (
    .tmr_expired_i  (tmr_expired_i),
    .loss_i         (loss_i),
    .spll_expired_i (spll_expired_i),
    .pass_o         (pass)
  );

  // outputs registered from the next state so the pin never glitches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_rst_n_o <= 1'b1;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      fail_o      <= 1'b0;
    end else begin
      dev_rst_n_o <= ~st_pin_low(state_d);
      busy_o      <= st_busy(state_d);
      done_o      <= (state_d == ST_DONE);
      fail_o      <= (state_d == ST_FAIL);
    end
  end

endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
  parameter int unsigned       CYC_PER_MS   = 50000,
  parameter int unsigned       HOLD_MS      = 4,
  parameter int unsigned       N_LOSS       = 4,
  parameter logic [N_LOSS-1:0] MONITOR_MASK = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              tmr_expired_i,
  input logic [N_LOSS-1:0] loss_i,
  input logic              spll_expired_i,
  input logic              dev_rst_n_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o
);

  localparam int unsigned HOLD_CYC = HOLD_MS * CYC_PER_MS;

  logic [31:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
    end else if (!dev_rst_n_o) begin
      low_run <= low_run + 1'b1;
    end else begin
      low_run <= '0;
    end
  end

  AST_PIN_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> dev_rst_n_o); // R1
  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n) (!busy_o && start_i) |=> (busy_o && !dev_rst_n_o && !done_o && !fail_o)); // R2
  AST_HOLD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) $rose(dev_rst_n_o) |-> (low_run == HOLD_CYC)); // R2
  AST_DONE_NEEDS_PASS: assert property (@(posedge clk) disable iff (!rst_n) $rose(done_o) |-> $past(tmr_expired_i && spll_expired_i && ((loss_i & MONITOR_MASK) == '0))); // R4
  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({busy_o, done_o, fail_o})); // R7
  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (done_o && !start_i) |=> done_o); // R9
  AST_FAIL_HELD: assert property (@(posedge clk) disable iff (!rst_n) (fail_o && !start_i) |=> fail_o); // R9

endmodule

bind dev_reset_seq rstseq_chk #(
  .CYC_PER_MS   (CYC_PER_MS),
  .HOLD_MS      (HOLD_A_MS + HOLD_B_MS + HOLD_C_MS),
  .N_LOSS       (N_LOSS),
  .MONITOR_MASK (MONITOR_MASK)
) u_rstseq_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .tmr_expired_i  (tmr_expired_i),
  .loss_i         (loss_i),
  .spll_expired_i (spll_expired_i),
  .dev_rst_n_o    (dev_rst_n_o),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .fail_o         (fail_o)
);

// File: tb/test_dev_reset_seq.sv
module test_dev_reset_seq;

  localparam int CPM      = 10;
  localparam int NL       = 4;
  localparam logic [NL-1:0] MASK = 4'b0111;
  localparam int HOLD     = 4 * CPM;
  localparam int CHK_REL  = 20 * CPM;
  localparam int P        = 20 * CPM + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic          tmr;
  logic [NL-1:0] loss;
  logic          spll;
  logic          dev_rst_n, busy, done, fail;

  always #10 clk = ~clk;

  dev_reset_seq #(
    .CYC_PER_MS   (CPM),
    .N_LOSS       (NL),
    .MONITOR_MASK (MASK)
  ) i_dev_reset_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start),
    .tmr_expired_i  (tmr),
    .loss_i         (loss),
    .spll_expired_i (spll),
    .dev_rst_n_o    (dev_rst_n),
    .busy_o         (busy),
    .done_o         (done),
    .fail_o         (fail)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;

  typedef struct {
    bit    is_done;
    int    at_cyc;
    string req;
  } exp_t;
  exp_t sb_q[$];

  int            run_t0 = 0;
  bit            run_on = 1'b0;
  bit            pl_tmr [3];
  bit            pl_spll[3];
  logic [NL-1:0] pl_loss[3];

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_plan(input int k, input bit t, input bit s, input logic [NL-1:0] l);
    pl_tmr[k]  = t;
    pl_spll[k] = s;
    pl_loss[k] = l;
  endtask

  // driver: launch a sequence and push the expected result
  task automatic run_seq(input bit exp_done, input int n_att, input string req);
    exp_t e;
    @(negedge clk);
    start  = 1'b1;
    run_t0 = cyc + 1;
    run_on = 1'b1;
    e.is_done = exp_done;
    e.at_cyc  = run_t0 + n_att * P;
    e.req     = req;
    sb_q.push_back(e);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic goto_rel(input int r);
    while (cyc < run_t0 + r) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_result();
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // status driver: failing pattern except in each planned sampling cycle (R10)
  initial begin
    int rel;
    tmr  = 1'b0;
    spll = 1'b0;
    loss = '1;
    forever begin
      @(negedge clk);
      rel = cyc - run_t0;
      if (run_on && rel >= 0 && (rel % P) == CHK_REL && (rel / P) < 3) begin
        tmr  = pl_tmr[rel / P];
        spll = pl_spll[rel / P];
        loss = pl_loss[rel / P];
      end else begin
        tmr  = 1'b0;
        spll = 1'b0;
        loss = '1;
      end
    end
  end

  // monitor: compare each result edge against the scoreboard
  initial begin
    bit pd, pf;
    exp_t e;
    pd = 1'b0;
    pf = 1'b0;
    forever begin
      @(negedge clk);
      if ((done && !pd) || (fail && !pf)) begin
        if (sb_q.size() == 0) begin
          chk("R8", "unexpected result", 1, 0);
        end else begin
          e = sb_q.pop_front();
          chk(e.req, "result is done", int'(done), int'(e.is_done));
          chk(e.req, "result cycle", cyc, e.at_cyc);
        end
      end
      pd = done;
      pf = fail;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    for (int k = 0; k < 3; k++) set_plan(k, 1'b0, 1'b0, '1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pin after reset", int'(dev_rst_n), 1);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "done after reset", int'(done), 0);
    chk("R1", "fail after reset", int'(fail), 0);

    // clean first attempt
    set_plan(0, 1'b1, 1'b1, 4'b0000);
    run_seq(1'b1, 1, "R4,R10");
    goto_rel(0);
    chk("R2", "pin low at launch", int'(dev_rst_n), 0);
    chk("R2", "busy at launch", int'(busy), 1);
    goto_rel(HOLD - 1);
    chk("R2", "pin low at end of hold", int'(dev_rst_n), 0);
    goto_rel(HOLD);
    chk("R3", "pin released", int'(dev_rst_n), 1);
    goto_rel(CHK_REL);
    chk("R3", "busy in sampling cycle", int'(busy), 1);
    chk("R3", "no early done", int'(done), 0);
    wait_result();

    // done held, then second attempt passes
    repeat (30) @(negedge clk);
    chk("R9", "done held", int'(done), 1);
    set_plan(0, 1'b0, 1'b1, 4'b0000);
    set_plan(1, 1'b1, 1'b1, 4'b0000);
    run_seq(1'b1, 2, "R6");
    goto_rel(0);
    chk("R9", "done cleared by start", int'(done), 0);
    goto_rel(P - 1);
    chk("R6", "pin high in sampling cycle", int'(dev_rst_n), 1);
    goto_rel(P);
    chk("R6", "pin low on retry", int'(dev_rst_n), 0);
    goto_rel(P + HOLD);
    chk("R6", "pin released on retry", int'(dev_rst_n), 1);
    wait_result();

    // three failures of different kinds
    set_plan(0, 1'b1, 1'b1, 4'b0001);
    set_plan(1, 1'b1, 1'b0, 4'b0000);
    set_plan(2, 1'b0, 1'b1, 4'b0100);
    run_seq(1'b0, 3, "R7");
    wait_result();
    chk("R7", "fail set", int'(fail), 1);
    chk("R7", "busy clear", int'(busy), 0);
    chk("R7", "pin high after fail", int'(dev_rst_n), 1);
    chk("R7", "done clear", int'(done), 0);
    repeat (25) @(negedge clk);
    chk("R9", "fail held", int'(fail), 1);

    // unmonitored flag set, plus start while busy
    set_plan(0, 1'b1, 1'b1, 4'b1000);
    run_seq(1'b1, 1, "R5");
    goto_rel(0);
    chk("R9", "fail cleared by start", int'(fail), 0);
    goto_rel(HOLD + 10);
    pulse_start();
    goto_rel(HOLD + 13);
    chk("R8", "pin stays high after busy start", int'(dev_rst_n), 1);
    chk("R8", "busy after ignored start", int'(busy), 1);
    wait_result();

    summary();
    $finish;
  end

endmodule